// File: doc/BRIEF.md
# Dual-Comparator Periodic Timer with Pin Output

This block is a free-running periodic counter with two compare values that drives a single output pin. A 10-bit count advances on each clock where the clock-enable strobe is high and the block is switched on. The full-width compare value `cmp_a` is checked against every count bit. The narrow compare value `cmp_p` is checked only against the three most significant count bits. Each compare event, and each wrap past the all-ones count, sets a sticky flag. Software clears a flag by pulsing the matching bit of `flag_clr`.

The block has three behaviours. In plain timer mode the pin stays low. In compare-output mode the pin starts from a programmed level and a compare-A event changes it: it can be forced low, forced high, toggled, or left alone. In PWM mode the period is set by compare P and the duty by compare A. A final inversion stage applies to the pin in both output modes.

Top module: `ptm_timer`

## Requirements
- R1: While `rst` is high and on the first clock after it, `count` is 0, all three flags are 0 and `pin` is 0. After reset the mode is timer (`mode` = 00).
- R2: The count starts from 0. When `run` is low, `count` is forced to 0 on the next clock. When `run` is high, `count` advances by one only on clocks where `tick` is high, and otherwise holds.
- R3: When `clr_sel` is 1 and the mode is not PWM (`mode` = 10), the count returns to 0 on the tick after it equals `cmp_a`. The period is therefore `cmp_a`+1 ticks.
- R4: Compare P fires on a tick when `cmp_p` is nonzero and `count` equals `cmp_p`·128. This means the top three bits equal `cmp_p` and the low seven bits are zero. With `clr_sel` = 0, that event returns the count to 0.
- R5: When `cmp_p` is 0, compare P never fires. The count runs from 1023 back to 0, and each such wrap on a tick sets `ovf`.
- R6: `hit_a`, `hit_p` and `ovf` are set by their events and stay set until cleared by `flag_clr` bit 0, 1 or 2 respectively. If a set and a clear arrive on the same clock, the set wins.
- R7: Compare-output mode is `mode` = 01. On a compare-A event the output acts according to the latched action code: 00 no change, 01 drive low, 10 drive high, 11 toggle.
- R8: In compare-output mode, the first clock with `run` high after a clock with it low loads `lvl` into the output. A compare-A event on that same clock applies its action to the newly loaded `lvl`.
- R9: The action code `act` is captured only on clocks where `run` is low. Changes made while `run` is high have no effect on the pin.
- R10: In PWM mode (`mode` = 10), `clr_sel` is ignored and the period comes from compare P (or from the wrap when `cmp_p` is 0). The pre-inversion output is `lvl` while `run` is high and `count` < `cmp_a`. Otherwise it is the complement of `lvl`, and it is always the complement while `run` is low.
- R11: In compare-output and PWM modes, `pin` is the output XOR `inv`. In timer mode (`mode` 00 or 11), `pin` is 0 whatever `lvl` and `inv` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable strobe |
| run | input | 1 | Timer on/off |
| mode | input | 2 | 00 timer, 01 compare output, 10 PWM, 11 timer |
| act | input | 2 | Compare-A action code |
| lvl | input | 1 | Initial level (compare) / active level (PWM) |
| inv | input | 1 | Pin inversion |
| clr_sel | input | 1 | 1: clear on compare A, 0: clear on compare P or wrap |
| cmp_a | input | CNT_W | Compare A value |
| cmp_p | input | CCRP_W | Compare P value for the top count bits |
| flag_clr | input | 3 | Flag clear strobes: bit0 A, bit1 P, bit2 overflow |
| count | output | CNT_W | Current count |
| pin | output | 1 | Output pin level |
| hit_a | output | 1 | Sticky compare-A flag |
| hit_p | output | 1 | Sticky compare-P flag |
| ovf | output | 1 | Sticky wrap flag |

## Verification
Two coincidences need care. The first is re-arming on the rising edge of `run` while compare A fires in the same clock. The bench provokes it by setting `cmp_a` to 0 with `clr_sel` set, so that the match lands on the very first running clock. The expected pin is the action applied to `lvl`, not to the previous output. The second is a flag set coinciding with its clear strobe: the bench pulses `flag_clr` on the cycle the counter hits a compare, and the flag must stay set. Both cases are judged against a cycle model in the bench, which is computed from the requirements and compared every clock.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER   = 2'b00,
        MODE_COMPARE = 2'b01,
        MODE_PWM     = 2'b10,
        MODE_SPARE   = 2'b11
    } ptm_mode_e;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } ptm_act_e;

    typedef struct packed {
        logic wrap;
        logic hit_p;
        logic hit_a;
    } ptm_evt_t;

    localparam int FLAG_N = 3;

    function automatic logic apply_act(input ptm_act_e a, input logic cur);
        logic r;
        case (a)
            ACT_LOW:    r = 1'b0;
            ACT_HIGH:   r = 1'b1;
            ACT_TOGGLE: r = ~cur;
            default:    r = cur;
        endcase
        return r;
    endfunction

    function automatic logic is_output_mode(input ptm_mode_e m);
        return (m == MODE_COMPARE) || (m == MODE_PWM);
    endfunction

endpackage

// File: rtl/ptm_counter.sv
module ptm_counter
    import ptm_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int CCRP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run,
    input  ptm_mode_e         mode,
    input  logic              clr_sel,
    input  logic [CNT_W-1:0]  cmp_a,
    input  logic [CCRP_W-1:0] cmp_p,
    output logic [CNT_W-1:0]  cnt,
    output ptm_evt_t          evt
);
    localparam int LOW_W = CNT_W - CCRP_W;

    logic step;
    logic use_a;
    logic clr_now;

    assign step = run && tick;

    always_comb begin
        evt = '0;
        if (step) begin
            evt.hit_a = (cnt == cmp_a);
            evt.hit_p = (cmp_p != '0)
                     && (cnt[CNT_W-1 -: CCRP_W] == cmp_p)
                     && (cnt[LOW_W-1:0] == '0);
            evt.wrap  = &cnt;
        end
    end

    // PWM always takes its period from compare P
    assign use_a   = (mode != MODE_PWM) && clr_sel;
    assign clr_now = use_a ? evt.hit_a
                           : ((cmp_p == '0) ? evt.wrap : evt.hit_p);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= clr_now ? '0 : cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ptm_flags.sv
module ptm_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else begin
                q[i] <= set[i] | (q[i] & ~clr[i]);
            end
        end
    end
endmodule

// File: rtl/ptm_outstage.sv
module ptm_outstage
    import ptm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  ptm_mode_e        mode,
    input  ptm_act_e         act,
    input  logic             lvl,
    input  logic             inv,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic             hit_a,
    output logic             pin
);
    logic     run_q;
    ptm_act_e act_q;
    logic     o_cmp;
    logic     base;
    logic     o_next;
    logic     pwm_core;
    logic     core;

    assign base   = (run && !run_q) ? lvl : o_cmp;
    assign o_next = hit_a ? apply_act(act_q, base) : base;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            act_q <= ACT_KEEP;
            o_cmp <= 1'b0;
        end else begin
            run_q <= run;
            if (!run) begin
                act_q <= act;
            end
            if (mode == MODE_COMPARE) begin
                o_cmp <= o_next;
            end
        end
    end

    assign pwm_core = (run && (cnt < cmp_a)) ? lvl : ~lvl;
    assign core     = (mode == MODE_COMPARE) ? o_cmp : pwm_core;
    assign pin      = is_output_mode(mode) ? (core ^ inv) : 1'b0;

endmodule

// File: rtl/ptm_timer.sv
module ptm_timer
    import ptm_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int CCRP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run,
    input  logic [1:0]        mode,
    input  logic [1:0]        act,
    input  logic              lvl,
    input  logic              inv,
    input  logic              clr_sel,
    input  logic [CNT_W-1:0]  cmp_a,
    input  logic [CCRP_W-1:0] cmp_p,
    input  logic [2:0]        flag_clr,
    output logic [CNT_W-1:0]  count,
    output logic              pin,
    output logic              hit_a,
    output logic              hit_p,
    output logic              ovf
);
    ptm_mode_e         mode_e;
    ptm_act_e          act_e;
    ptm_evt_t          evt;
    logic [FLAG_N-1:0] flag_q;

    assign mode_e = ptm_mode_e'(mode);
    assign act_e  = ptm_act_e'(act);

    ptm_counter #(.CNT_W(CNT_W), .CCRP_W(CCRP_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run     (run),
        .mode    (mode_e),
        .clr_sel (clr_sel),
        .cmp_a   (cmp_a),
        .cmp_p   (cmp_p),
        .cnt     (count),
        .evt     (evt)
    );

    ptm_flags #(.N(FLAG_N)) u_flags (
        .clk (clk),
        .rst (rst),
        .set (evt),
        .clr (flag_clr),
        .q   (flag_q)
    );

    ptm_outstage #(.CNT_W(CNT_W)) u_out (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .mode  (mode_e),
        .act   (act_e),
        .lvl   (lvl),
        .inv   (inv),
        .cnt   (count),
        .cmp_a (cmp_a),
        .hit_a (evt.hit_a),
        .pin   (pin)
    );

    assign hit_a = flag_q[0];
    assign hit_p = flag_q[1];
    assign ovf   = flag_q[2];

endmodule

// File: rtl/ptm_timer_chk.sv
module ptm_timer_chk #(
    parameter int CNT_W  = 10,
    parameter int CCRP_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              run,
    input logic [1:0]        mode,
    input logic              lvl,
    input logic              inv,
    input logic              clr_sel,
    input logic [CNT_W-1:0]  cmp_a,
    input logic [2:0]        flag_clr,
    input logic [CNT_W-1:0]  count,
    input logic              pin,
    input logic              hit_p,
    input logic              ovf
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> count == '0);

    assert_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !tick ##1 run) |-> $stable(count));

    assert_clear_a_R3: assert property (@(posedge clk) disable iff (rst)
        (run && tick && clr_sel && mode != 2'b10 && count == cmp_a) |=> count == '0);

    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (run && tick && (&count)) |=> (ovf && count == '0));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (hit_p && !flag_clr[1]) |=> hit_p);

    assert_pwm_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && !run) |-> pin == (~lvl ^ inv));

    assert_timer_pin_R11: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 || mode == 2'b11) |-> !pin);
endmodule

bind ptm_timer ptm_timer_chk #(.CNT_W(CNT_W), .CCRP_W(CCRP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .run      (run),
    .mode     (mode),
    .lvl      (lvl),
    .inv      (inv),
    .clr_sel  (clr_sel),
    .cmp_a    (cmp_a),
    .flag_clr (flag_clr),
    .count    (count),
    .pin      (pin),
    .hit_p    (hit_p),
    .ovf      (ovf)
);

// File: tb/ptm_timer_test.sv
`timescale 1ns/1ps
module ptm_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       run = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [1:0] act = 2'b00;
    logic       lvl = 1'b0;
    logic       inv = 1'b0;
    logic       clr_sel = 1'b0;
    logic [9:0] cmp_a = '0;
    logic [2:0] cmp_p = '0;
    logic [2:0] flag_clr = '0;
    logic [9:0] count;
    logic       pin, hit_a, hit_p, ovf;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    // bench model state
    logic [9:0] m_cnt = '0;
    logic       m_fa = 0, m_fp = 0, m_fo = 0, m_out = 0, m_runq = 0;
    logic [1:0] m_act = '0;

    always #2.5 clk = ~clk;

    ptm_timer uut (
        .clk(clk), .rst(rst), .tick(tick), .run(run), .mode(mode), .act(act),
        .lvl(lvl), .inv(inv), .clr_sel(clr_sel), .cmp_a(cmp_a), .cmp_p(cmp_p),
        .flag_clr(flag_clr), .count(count), .pin(pin), .hit_a(hit_a),
        .hit_p(hit_p), .ovf(ovf)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, got, exp, $time);
        end
    endtask

    function automatic logic exp_pin();
        case (mode)
            2'b01:   return m_out ^ inv;
            2'b10:   return ((run && (m_cnt < cmp_a)) ? lvl : ~lvl) ^ inv;
            default: return 1'b0;
        endcase
    endfunction

    task automatic compare_all();
        chk("R2", "count", int'(count), int'(m_cnt));
        chk("R6", "hit_a", int'(hit_a), int'(m_fa));
        chk("R6", "hit_p", int'(hit_p), int'(m_fp));
        chk("R6", "ovf", int'(ovf), int'(m_fo));
        chk(cur_req, "pin", int'(pin), int'(exp_pin()));
    endtask

    // one clock: predict from the requirements, advance, compare at negedge
    task automatic step();
        logic rise, ma, mp, wr, clr, base, nout;
        logic [9:0] ncnt;
        logic [1:0] nact;
        rise = run && !m_runq;
        ma = 0; mp = 0; wr = 0;
        if (run && tick) begin
            ma = (m_cnt == cmp_a);
            mp = (cmp_p != 0) && (m_cnt == {cmp_p, 7'd0});
            wr = (m_cnt == 10'h3FF);
        end
        if (mode != 2'b10 && clr_sel) clr = ma;
        else clr = (cmp_p == 0) ? wr : mp;
        ncnt = !run ? 10'd0 : (tick ? (clr ? 10'd0 : m_cnt + 10'd1) : m_cnt);
        nout = m_out;
        if (mode == 2'b01) begin
            base = rise ? lvl : m_out;
            nout = base;
            if (ma) begin
                case (m_act)
                    2'b01: nout = 1'b0;
                    2'b10: nout = 1'b1;
                    2'b11: nout = ~base;
                    default: nout = base;
                endcase
            end
        end
        nact = !run ? act : m_act;
        @(posedge clk);
        m_cnt = ncnt;
        m_fa = ma | (m_fa & ~flag_clr[0]);
        m_fp = mp | (m_fp & ~flag_clr[1]);
        m_fo = wr | (m_fo & ~flag_clr[2]);
        m_out = nout;
        m_act = nact;
        m_runq = run;
        @(negedge clk);
        compare_all();
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_flags();
        flag_clr = 3'b111;
        step();
        flag_clr = 3'b000;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "count in reset", int'(count), 0);
        chk("R1", "pin in reset", int'(pin), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        compare_all();
        chk("R1", "flags after reset", int'({hit_a, hit_p, ovf}), 0);

        // R3 / R2: clear on compare A, with tick gating
        cur_req = "R11";
        clr_sel = 1'b1;
        tick = 1'b1;
        lvl = 1'b1; inv = 1'b1;
        foreach (cmp_a_list[k]) begin
            cmp_a = cmp_a_list[k];
            run = 1'b1;
            steps(40);
            tick = 1'b0; steps(3);   // R2 hold while tick low
            tick = 1'b1; steps(20);
            run = 1'b0; steps(2);
            clear_flags();
        end
        chk("R3", "count idle", int'(count), 0);

        // R4: clear on compare P
        clr_sel = 1'b0;
        cmp_a = 10'd50;
        cmp_p = 3'd1;
        run = 1'b1;
        steps(300);
        chk("R4", "hit_p seen", int'(hit_p), 1);
        // R6: set and clear on the same clock (count 128 reached after the 129-tick period)
        run = 1'b0; step(); clear_flags();
        run = 1'b1;
        steps(128);
        flag_clr = 3'b010;   // clear strobe in the compare-P clock
        step();
        flag_clr = 3'b000;
        chk("R6", "set beats clear", int'(hit_p), 1);
        run = 1'b0; step(); clear_flags();

        // R5: wrap with cmp_p = 0
        cmp_p = 3'd0;
        cmp_a = 10'd1000;
        run = 1'b1;
        steps(1030);
        chk("R5", "ovf after wrap", int'(ovf), 1);
        run = 1'b0; step(); clear_flags();

        // R7 / R11: compare-output actions over all codes and levels
        cur_req = "R7";
        mode = 2'b01;
        clr_sel = 1'b1;
        cmp_a = 10'd7;
        for (int a = 0; a < 4; a++) begin
            for (int l = 0; l < 2; l++) begin
                for (int v = 0; v < 2; v++) begin
                    act = a[1:0]; lvl = l[0]; inv = v[0];
                    run = 1'b0; steps(2);
                    run = 1'b1; steps(30);
                end
            end
        end
        run = 1'b0; steps(2);

        // R9: act changed while running is ignored
        cur_req = "R9";
        act = 2'b11; lvl = 1'b0; inv = 1'b0;
        step();
        run = 1'b1; steps(3);
        act = 2'b10;
        steps(30);
        run = 1'b0; steps(2);

        // R8: rising edge and compare-A event in the same clock
        cur_req = "R8";
        cmp_a = 10'd0;
        act = 2'b11; lvl = 1'b1;
        step();
        run = 1'b1;
        step();
        chk("R8", "toggle on re-arm clock", int'(pin), 0);
        steps(5);
        run = 1'b0; steps(2);
        act = 2'b01; lvl = 1'b0; inv = 1'b1;
        step();
        run = 1'b1; steps(6);
        run = 1'b0; steps(2);

        // R10: PWM duty sweep, clr_sel ignored
        cur_req = "R10";
        mode = 2'b10;
        cmp_p = 3'd1;
        foreach (pwm_list[k]) begin
            for (int c = 0; c < 4; c++) begin
                cmp_a = pwm_list[k];
                lvl = c[0]; inv = c[1]; clr_sel = c[0];
                run = 1'b0; steps(2);
                run = 1'b1; steps(260);
            end
        end
        run = 1'b0; steps(3);

        // R11: timer modes keep the pin low
        cur_req = "R11";
        mode = 2'b11; lvl = 1'b1; inv = 1'b1;
        run = 1'b1; steps(20);
        chk("R11", "pin in spare mode", int'(pin), 0);
        run = 1'b0; steps(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    logic [9:0] cmp_a_list [4] = '{10'd0, 10'd1, 10'd5, 10'd37};
    logic [9:0] pwm_list   [3] = '{10'd0, 10'd40, 10'd200};

endmodule